// File: doc/BRIEF.md
# Wired Interrupt Aggregator

This block gathers up to 32 interrupt request lines into a single wired interrupt line that goes to a parent controller. Each request line owns one bit in every per-line register. Source events are captured into a pending-event register, called cause. A per-line block register, called mask, hides events from the parent. The output line is raised whenever an event is both captured and unmasked.

All lines share one trigger mode, chosen by a single control bit. In level mode, a line that is high sets its cause bit on every cycle. In rising-edge mode, only a fresh 0-to-1 transition of the synchronised line sets its cause bit.

Software uses a plain register port with write enable, read enable, address and data. It acknowledges events by writing an AND-mask into cause. It forces events again through a separate write-one-to-set register. It keeps a second control bit, which blocks message-signalled delivery, as plain stored state.

Top module: `wired_irq_agg`

## Requirements
- R1: After reset, mask reads 0xFFFFFFFF, cause reads 0, control reads 0 and `irq_o` is low.
- R2: The registers decode at byte offsets 0x00 (cause), 0x08 (set-cause), 0x10 (mask) and 0x28 (control). Mask reads back exactly what was last written to it.
- R3: A mask bit of 1 blocks its line and a 0 passes it. `irq_o` is high exactly when (cause AND NOT mask) is non-zero, and it follows a mask write on the cycle the write takes effect.
- R4: A write to cause leaves each cause bit equal to its old value AND the written bit. Writing all zeros clears every bit that has no new event in that cycle.
- R5: A write of 1 to a bit of set-cause sets that cause bit. A write of 0 leaves the bit unchanged. Reads of set-cause return 0.
- R6: Control bit 3 selects the trigger mode for all lines: 1 is rising edge and 0 is level-high. Control bit 5 is the message-signalled block bit, stored and read back. All other control bits read 0 and ignore writes.
- R7: In level mode, a cause bit is set on every cycle its synchronised line is high. A bit cleared by software reappears while the line stays high.
- R8: In edge mode, a line that rises sets its cause bit on the third clock edge after the change: two synchroniser stages plus one detect cycle. While the line stays high, a cleared bit stays cleared.
- R9: When a hardware set event and a software clear hit the same cause bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Raw interrupt request lines, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; read data is combinational |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | NUM_SRC | Write data |
| rdata | output | NUM_SRC | Read data; 0 when rd_en is low |
| irq_o | output | 1 | Wired interrupt toward the parent controller |

## Verification
The bench builds the block with its default parameters: 32 lines, a 6-bit offset and two synchroniser stages. The full width places the top line (bit 31) and the bottom line (bit 0) in the same words, so the AND-acknowledge and write-one-to-set rules are checked at both ends of the word. With two stages, the edge path has a fixed latency of three edges. The bench can therefore check that cause is still clear after the second edge and set after the third. It also lines up a software clear with that third edge to exercise the set-wins collision.

// File: rtl/agg_pkg.sv
package agg_pkg;
  localparam int OFF_CAUSE = 'h00;
  localparam int OFF_SETC  = 'h08;
  localparam int OFF_MASK  = 'h10;
  localparam int OFF_CTRL  = 'h28;
  localparam int CTRL_MODE_BIT = 3;
  localparam int CTRL_MSIB_BIT = 5;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_RISE  = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/agg_sync.sv
module agg_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/agg_trigger.sv
module agg_trigger
  import agg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  trig_mode_e   mode_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] hw_set_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  // Edge mode: only a fresh 0->1 of the synchronised line produces an event.
  always_comb begin
    if (mode_i == TRIG_RISE) hw_set_o = lvl_i & ~prev_q;
    else                     hw_set_o = lvl_i;
  end
endmodule

// File: rtl/agg_regfile.sv
module agg_regfile
  import agg_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      hw_set_i,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      cause_o,
  output logic [W-1:0]      mask_o,
  output trig_mode_e        mode_o
);
  logic [W-1:0] cause_q, cause_nxt, mask_q, ctrl_view;
  trig_mode_e   mode_q;
  logic         msib_q;
  logic         hit_cause, hit_setc, hit_mask, hit_ctrl;

  assign hit_cause = (addr == ADDR_W'(OFF_CAUSE));
  assign hit_setc  = (addr == ADDR_W'(OFF_SETC));
  assign hit_mask  = (addr == ADDR_W'(OFF_MASK));
  assign hit_ctrl  = (addr == ADDR_W'(OFF_CTRL));

  // Software clear and set first, hardware events last so they win.
  always_comb begin
    cause_nxt = cause_q;
    if (wr_en && hit_cause) cause_nxt = cause_nxt & wdata;
    if (wr_en && hit_setc)  cause_nxt = cause_nxt | wdata;
    cause_nxt = cause_nxt | hw_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '1;
      mode_q  <= TRIG_LEVEL;
      msib_q  <= 1'b0;
    end else begin
      cause_q <= cause_nxt;
      if (wr_en && hit_mask) mask_q <= wdata;
      if (wr_en && hit_ctrl) begin
        mode_q <= trig_mode_e'(wdata[CTRL_MODE_BIT]);
        msib_q <= wdata[CTRL_MSIB_BIT];
      end
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_MODE_BIT] = mode_q;
    ctrl_view[CTRL_MSIB_BIT] = msib_q;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit_cause)     rdata = cause_q;
      else if (hit_mask) rdata = mask_q;
      else if (hit_ctrl) rdata = ctrl_view;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/wired_irq_agg.sv
module wired_irq_agg
  import agg_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] src_sync_w, hw_set_w, cause_w, mask_w;
  trig_mode_e         mode_w;

  agg_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(src_sync_w)
  );

  agg_trigger #(.W(NUM_SRC)) u_trig (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_w),
    .lvl_i(src_sync_w), .hw_set_o(hw_set_w)
  );

  agg_regfile #(.W(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .hw_set_i(hw_set_w),
    .rdata(rdata), .cause_o(cause_w), .mask_o(mask_w), .mode_o(mode_w)
  );

  assign irq_o = |(cause_w & ~mask_w);
endmodule

// File: rtl/agg_chk.sv
module agg_chk
  import agg_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [NUM_SRC-1:0] wdata,
  input logic [NUM_SRC-1:0] rdata,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] cause_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] hw_set
);
  localparam logic [NUM_SRC-1:0] CTRL_KEEP =
    (NUM_SRC'(1) << CTRL_MODE_BIT) | (NUM_SRC'(1) << CTRL_MSIB_BIT);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == '1 && cause_q == '0 && !irq_o));

  assert_masked_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq_o);

  assert_ack_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFF_CAUSE))
      |=> ((cause_q & ~$past(wdata) & ~$past(hw_set)) == '0));

  assert_setc_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFF_SETC))
      |=> ((cause_q & $past(wdata)) == $past(wdata)));

  assert_setc_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(OFF_SETC)) |-> (rdata == '0));

  assert_ctrl_spare_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(OFF_CTRL)) |-> ((rdata & ~CTRL_KEEP) == '0));

  assert_hw_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((cause_q & $past(hw_set)) == $past(hw_set)));
endmodule

bind wired_irq_agg agg_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .cause_q(cause_w),
  .mask_q(mask_w), .hw_set(hw_set_w)
);

// File: tb/wired_irq_agg_tb.sv
module wired_irq_agg_tb;
  localparam int N = 32;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_CAUSE = 6'h00, A_SETC = 6'h08,
                            A_MASK = 6'h10, A_CTRL = 6'h28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_i = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wired_irq_agg #(.NUM_SRC(N), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [AW-1:0] a, logic [N-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(logic [AW-1:0] a, output logic [N-1:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    reg_rd(A_CAUSE, v); check("R1 cause", v, '0);
    reg_rd(A_MASK, v);  check("R1 mask", v, '1);
    reg_rd(A_CTRL, v);  check("R1 ctrl", v, '0);
    check("R1 irq", N'(irq_o), '0);
  endtask

  task automatic t_regs();
    logic [N-1:0] v;
    reg_wr(A_MASK, 32'hA5C3_0F1E);
    reg_rd(A_MASK, v); check("R2 mask readback", v, 32'hA5C3_0F1E);
    reg_wr(A_CTRL, 32'hFFFF_FFFF);
    reg_rd(A_CTRL, v); check("R6 ctrl spare bits", v, 32'h0000_0028);
    reg_wr(A_CTRL, 32'h0000_0020);
    reg_rd(A_CTRL, v); check("R6 msi block only", v, 32'h0000_0020);
    reg_wr(A_MASK, '1);
  endtask

  task automatic t_setc_ack();
    logic [N-1:0] v;
    reg_wr(A_SETC, 32'h8000_0001);
    reg_rd(A_CAUSE, v); check("R5 set-cause", v, 32'h8000_0001);
    reg_rd(A_SETC, v);  check("R5 set-cause reads 0", v, '0);
    check("R3 masked irq low", N'(irq_o), '0);
    reg_wr(A_MASK, 32'hFFFF_FFFE);
    check("R3 unmask bit0 irq high", N'(irq_o), 1);
    reg_wr(A_SETC, 32'h0000_0000);
    reg_rd(A_CAUSE, v); check("R5 zero write no effect", v, 32'h8000_0001);
    reg_wr(A_CAUSE, 32'hFFFF_FFFE);
    reg_rd(A_CAUSE, v); check("R4 ack bit0", v, 32'h8000_0000);
    check("R3 bit31 masked irq low", N'(irq_o), '0);
    reg_wr(A_MASK, 32'h7FFF_FFFF);
    check("R3 unmask bit31 irq high", N'(irq_o), 1);
    reg_wr(A_MASK, '1);
    check("R3 remask irq low", N'(irq_o), '0);
    reg_wr(A_CAUSE, '0);
    reg_rd(A_CAUSE, v); check("R4 clear all", v, '0);
  endtask

  task automatic t_level();
    logic [N-1:0] v;
    reg_wr(A_CTRL, 32'h0000_0000);
    src_i[5] = 1'b1;
    wait_cyc(4);
    reg_rd(A_CAUSE, v); check("R7 level sets", v, 32'h0000_0020);
    reg_wr(A_CAUSE, '0);
    reg_rd(A_CAUSE, v); check("R7 R9 level reappears", v, 32'h0000_0020);
    src_i[5] = 1'b0;
    wait_cyc(4);
    reg_wr(A_CAUSE, '0);
    reg_rd(A_CAUSE, v); check("R7 level released clears", v, '0);
  endtask

  task automatic t_edge();
    logic [N-1:0] v;
    reg_wr(A_CTRL, 32'h0000_0028);
    src_i[31] = 1'b1;
    wait_cyc(2);
    reg_rd(A_CAUSE, v); check("R8 not yet after 2 edges", v, '0);
    wait_cyc(1);
    reg_rd(A_CAUSE, v); check("R8 set after 3 edges", v, 32'h8000_0000);
    reg_wr(A_CAUSE, '0);
    wait_cyc(3);
    reg_rd(A_CAUSE, v); check("R8 held high stays clear", v, '0);
    src_i[31] = 1'b0;
    wait_cyc(4);
    src_i[31] = 1'b1;
    wait_cyc(4);
    reg_rd(A_CAUSE, v); check("R8 second rise sets", v, 32'h8000_0000);
    reg_wr(A_CAUSE, '0);
    src_i[31] = 1'b0;
    wait_cyc(3);
  endtask

  task automatic t_collide();
    logic [N-1:0] v;
    src_i[7] = 1'b1;
    wait_cyc(2);
    reg_wr(A_CAUSE, '0);
    reg_rd(A_CAUSE, v); check("R9 edge set beats clear", v, 32'h0000_0080);
    src_i[7] = 1'b0;
    reg_wr(A_CAUSE, '0);
    reg_rd(A_CAUSE, v); check("R4 cleared after collide", v, '0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_setc_ack();
    t_level();
    t_edge();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule